// File: doc/BRIEF.md
# RGB to YCbCr Matrix Converter

This block turns a stream of 10-bit-per-component RGB pixels into YCbCr through a programmable 3x3 fixed-point matrix. Each input component first gets a signed offset added. The three offset components are multiplied by one row of signed coefficients, and the products are summed at full width. The sum is rounded, scaled down, shifted by a per-output offset and clipped to the 10-bit range. Loading the standard HD limited-range coefficients gives Y in 64..940 and chroma centred on 512. Other matrices can be loaded for other conversions.

Software, or a sequencer, writes the offsets, the coefficients and a control word through a write-only register port. The writes land in a shadow copy. That copy is moved into the working set only on a frame-start pulse, so every pixel of a frame uses one coherent set. When the enable bit is clear, pixels come out unchanged with the same latency.

Top module: `rgb_ycc_csc`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is 0. Both the working and the shadow register sets clear to zero, so after reset the enable is off and pixels pass through unchanged.
- R2: Register layout. Values are two's complement, the shift field unsigned.
  - Address 0 holds the R pre-offset in bits 27:16 and the G pre-offset in 11:0. Address 1 holds the B pre-offset in 11:0.
  - Addresses 2 to 6 hold the nine 13-bit coefficients, row-major starting at c00. Each word holds two: the first in bits 28:16, the next in 12:0. Address 6 holds c22 in 28:16.
  - Address 7 holds the Y and Cb output offsets in 27:16 and 11:0. Address 8 holds the Cr offset in 11:0.
  - Address 9 is control: bit 0 is the enable and bits 18:16 the extra right shift.
- R3: With the enable set, output row i is floor((sum over j of (in_j + pre_j) * c_ij + 512) / 2^(10+shift)) + post_i. A coefficient of 1024 means a gain of one.
- R4: Each output component is clipped to 0..1023. A negative result gives 0 and a result above 1023 gives 1023.
- R5: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. The pixel presented with `in_valid` appears on `pix_out` in that same cycle.
- R6: With the enable clear, `pix_out` equals `pix_in` from 3 cycles earlier, bit for bit, whatever the coefficients and offsets hold.
- R7: A register write has no effect on the output until the next `frame_start` pulse. A pulse copies the shadow set as it stood before any write in that same cycle, so such a write waits for the following pulse.
- R8: Pixel packing: the input carries R in bits 29:20, G in 19:10 and B in 9:0. The output carries Y in 29:20, Cb in 19:10 and Cr in 9:0.
- R9: With the HD limited-range set loaded, the outputs are as follows. The coefficients are Y 186, 627, 63; Cb -103, -345, 448; Cr 448, -407, -41. The output offsets are 64, 512 and 512, with zero pre-offsets and zero shift.
  - Black gives (64, 512, 512).
  - Full white gives (939, 512, 512).
  - Full red gives (250, 409, 960).
- R10: The shift field adds its value to the 10-bit scaling shift. With a unity diagonal and shift 1, an input of 600 becomes 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse that commits the shadow registers |
| in_valid | input | 1 | Input pixel qualifier |
| pix_in | input | 30 | Packed R, G, B input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 30 | Packed Y, Cb, Cr output pixel (or the input pixel when bypassed) |

## Verification
The standard HD matrix is tried first with black, white and pure red, whose results are worked out by hand. These separate a wrong coefficient sign, a misplaced output offset and swapped component positions. A back-to-back stream of mixed pixels follows, checked against an arithmetic model, which exposes pipeline misalignment between neighbouring pixels. An asymmetric matrix with negative offsets catches swapped register fields. A unity matrix with extreme pre-offsets drives both clip limits and the extra shift. Writes are also issued without a frame pulse and in the same cycle as one; the results tell a committed set apart from a pending one.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int PIX_W   = 10;   // bits per colour component
    localparam int NCOMP   = 3;    // components per pixel
    localparam int COEF_W  = 13;   // signed coefficient width
    localparam int OFS_W   = 12;   // signed offset width
    localparam int FRAC_W  = 10;   // coefficient fraction bits (1024 = 1.0)
    localparam int SHIFT_W = 3;    // extra right-shift field width
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    localparam int NCOEF   = NCOMP * NCOMP;
    localparam int PIXV_W  = NCOMP * PIX_W;
    localparam int AW      = ((PIX_W + 1 > OFS_W) ? PIX_W + 1 : OFS_W) + 1;
    localparam int PROD_W  = AW + COEF_W;
    localparam int SUM_W   = PROD_W + $clog2(NCOMP);
    localparam int EXT_W   = SUM_W + 2;
    localparam int SHAMT_W = $clog2(FRAC_W + (1 << SHIFT_W));
    localparam int HI_LSB  = 16;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_PRE_RG  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRE_B   = 4'd1;
    localparam logic [ADDR_W-1:0] A_COEF_0  = 4'd2;
    localparam logic [ADDR_W-1:0] A_COEF_1  = 4'd3;
    localparam logic [ADDR_W-1:0] A_COEF_2  = 4'd4;
    localparam logic [ADDR_W-1:0] A_COEF_3  = 4'd5;
    localparam logic [ADDR_W-1:0] A_COEF_4  = 4'd6;
    localparam logic [ADDR_W-1:0] A_POST_YC = 4'd7;
    localparam logic [ADDR_W-1:0] A_POST_R  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd9;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_SH_LSB = 16;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [COEF_W-1:0] coef_t;

    typedef struct packed {
        ofs_t  [NCOMP-1:0] pre;
        coef_t [NCOEF-1:0] coef;
        ofs_t  [NCOMP-1:0] post;
        logic  [SHIFT_W-1:0] shift;
        logic  en;
    } csc_cfg_t;

    // unsigned component plus signed offset, widened to AW
    function automatic logic signed [AW-1:0] pre_add(input logic [PIX_W-1:0] p,
                                                    input ofs_t o);
        logic signed [AW-1:0] pe;
        logic signed [AW-1:0] oe;
        pe = $signed({{(AW-PIX_W){1'b0}}, p});
        oe = $signed({{(AW-OFS_W){o[OFS_W-1]}}, o});
        return pe + oe;
    endfunction

    function automatic logic [PIX_W-1:0] clip_pix(input logic signed [EXT_W-1:0] v);
        logic signed [EXT_W-1:0] top;
        top = $signed({{(EXT_W-PIX_W){1'b0}}, {PIX_W{1'b1}}});
        if (v < 0)
            return '0;
        else if (v > top)
            return {PIX_W{1'b1}};
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_start,
    output csc_cfg_t          shadow,
    output csc_cfg_t          active
);

    ofs_t  w_hi_ofs, w_lo_ofs;
    coef_t w_hi_cf,  w_lo_cf;
    logic  unused_wbits;

    assign w_hi_ofs = wdata[HI_LSB +: OFS_W];
    assign w_lo_ofs = wdata[0 +: OFS_W];
    assign w_hi_cf  = wdata[HI_LSB +: COEF_W];
    assign w_lo_cf  = wdata[0 +: COEF_W];
    assign unused_wbits = ^{wdata[DATA_W-1:HI_LSB+COEF_W], wdata[HI_LSB-1:COEF_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            // commit sees the shadow value from before this cycle's write
            if (frame_start)
                active <= shadow;
            if (we) begin
                case (addr)
                    A_PRE_RG:  begin shadow.pre[0]  <= w_hi_ofs; shadow.pre[1]  <= w_lo_ofs; end
                    A_PRE_B:   begin shadow.pre[2]  <= w_lo_ofs; end
                    A_COEF_0:  begin shadow.coef[0] <= w_hi_cf;  shadow.coef[1] <= w_lo_cf;  end
                    A_COEF_1:  begin shadow.coef[2] <= w_hi_cf;  shadow.coef[3] <= w_lo_cf;  end
                    A_COEF_2:  begin shadow.coef[4] <= w_hi_cf;  shadow.coef[5] <= w_lo_cf;  end
                    A_COEF_3:  begin shadow.coef[6] <= w_hi_cf;  shadow.coef[7] <= w_lo_cf;  end
                    A_COEF_4:  begin shadow.coef[8] <= w_hi_cf;  end
                    A_POST_YC: begin shadow.post[0] <= w_hi_ofs; shadow.post[1] <= w_lo_ofs; end
                    A_POST_R:  begin shadow.post[2] <= w_lo_ofs; end
                    A_CTRL:    begin
                        shadow.en    <= wdata[CTRL_EN_BIT];
                        shadow.shift <= wdata[CTRL_SH_LSB +: SHIFT_W];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csc_lane.sv
module csc_lane
    import csc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCOMP-1:0][AW-1:0]   a,
    input  coef_t [NCOMP-1:0]          c,
    input  ofs_t                       post,
    input  logic [SHIFT_W-1:0]         shift,
    output logic [PIX_W-1:0]           y
);

    localparam logic signed [EXT_W-1:0] RND = EXT_W'(1 << (FRAC_W - 1));

    logic signed [PROD_W-1:0] prod [NCOMP];
    logic signed [SUM_W-1:0]  sum_d, sum_q;
    logic signed [EXT_W-1:0]  sum_ext, post_ext, scaled, val;
    logic [SHAMT_W-1:0]       shamt;

    // stage 2: products summed at full precision
    always_comb begin
        sum_d = '0;
        for (int j = 0; j < NCOMP; j++) begin
            prod[j] = $signed(a[j]) * $signed(c[j]);
            sum_d   = sum_d + SUM_W'(prod[j]);
        end
    end

    // stage 3: round, scale, offset, clip
    always_comb begin
        shamt    = SHAMT_W'(FRAC_W) + SHAMT_W'(shift);
        sum_ext  = sum_q;
        post_ext = $signed({{(EXT_W-OFS_W){post[OFS_W-1]}}, post});
        scaled   = (sum_ext + RND) >>> shamt;
        val      = scaled + post_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            y     <= '0;
        end else begin
            sum_q <= sum_d;
            y     <= clip_pix(val);
        end
    end

endmodule

// File: rtl/rgb_ycc_csc.sv
module rgb_ycc_csc
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIXV_W-1:0] pix_in,
    output logic              out_valid,
    output logic [PIXV_W-1:0] pix_out
);

    localparam int LAT = 3;

    csc_cfg_t cfg_shadow, cfg_active;

    csc_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .frame_start (frame_start),
        .shadow      (cfg_shadow),
        .active      (cfg_active)
    );

    // side pipeline: valid, enable and raw pixel for bypass
    logic [LAT-1:0]             vld_sr, en_sr;
    logic [LAT-1:0][PIXV_W-1:0] pix_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
            en_sr  <= '0;
            pix_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], in_valid};
            en_sr  <= {en_sr[LAT-2:0], cfg_active.en};
            pix_sr <= {pix_sr[LAT-2:0], pix_in};
        end
    end

    // stage 1: pre-offset per input component (index 0 = R)
    logic [NCOMP-1:0][AW-1:0] a_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            for (int i = 0; i < NCOMP; i++)
                a_q[i] <= pre_add(pix_in[(NCOMP-1-i)*PIX_W +: PIX_W], cfg_active.pre[i]);
        end
    end

    logic [PIXV_W-1:0] ycc;

    for (genvar r = 0; r < NCOMP; r++) begin : g_lane
        csc_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .a     (a_q),
            .c     (cfg_active.coef[r*NCOMP +: NCOMP]),
            .post  (cfg_active.post[r]),
            .shift (cfg_active.shift),
            .y     (ycc[(NCOMP-1-r)*PIX_W +: PIX_W])
        );
    end

    assign out_valid = vld_sr[LAT-1];
    assign pix_out   = en_sr[LAT-1] ? ycc : pix_sr[LAT-1];

endmodule

// File: rtl/csc_checker.sv
module csc_checker
    import csc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PIXV_W-1:0] pix_in,
    input logic              out_valid,
    input logic [PIXV_W-1:0] pix_out,
    input logic              frame_start,
    input csc_cfg_t          cfg_shadow,
    input csc_cfg_t          cfg_active
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1: reset clears valid and the working set
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && cfg_active == '0));

    // R5: fixed three-cycle valid delay
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: disabled conversion returns the input pixel untouched
    a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && !$past(cfg_active.en, 3))
            |-> (pix_out == $past(pix_in, 3)));

    // R7: working set only moves on a frame pulse
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_active));

    // R7: frame pulse loads the pre-write shadow contents
    a_r7_commit: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cfg_active == $past(cfg_shadow)));

endmodule

bind rgb_ycc_csc csc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .pix_in      (pix_in),
    .out_valid   (out_valid),
    .pix_out     (pix_out),
    .frame_start (frame_start),
    .cfg_shadow  (cfg_shadow),
    .cfg_active  (cfg_active)
);

// File: tb/rgb_ycc_csc_tb.sv
module rgb_ycc_csc_tb;
    import csc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [29:0] pix_in = '0;
    logic        out_valid;
    logic [29:0] pix_out;

    always #10 clk = ~clk;   // 50 MHz

    rgb_ycc_csc u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .pix_in(pix_in),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench-side configuration mirror
    int pre[3], cf[9], post[3], sh, en;

    localparam int NSTIM = 8;
    localparam logic [29:0] STIM [NSTIM] = '{
        {10'd0,    10'd0,    10'd0},
        {10'd1023, 10'd1023, 10'd1023},
        {10'd512,  10'd256,  10'd128},
        {10'd17,   10'd900,  10'd333},
        {10'd1023, 10'd0,    10'd1023},
        {10'd0,    10'd1023, 10'd0},
        {10'd700,  10'd20,   10'd999},
        {10'd64,   10'd940,  10'd512}
    };

    function automatic logic [29:0] ycc(int y, int cb, int cr);
        return {y[9:0], cb[9:0], cr[9:0]};
    endfunction

    function automatic logic [29:0] model(logic [29:0] p);
        logic [29:0] r;
        if (en == 0) return p;
        for (int o = 0; o < 3; o++) begin
            longint acc = 0;
            longint v;
            for (int j = 0; j < 3; j++)
                acc += (longint'(p[(2-j)*10 +: 10]) + pre[j]) * cf[o*3+j];
            v = ((acc + 512) >>> (10 + sh)) + post[o];
            if (v < 0) v = 0;
            if (v > 1023) v = 1023;
            r[(2-o)*10 +: 10] = v[9:0];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [29:0] got, logic [29:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] pk12(int hi, int lo);
        return {4'b0, hi[11:0], 4'b0, lo[11:0]};
    endfunction

    function automatic logic [31:0] pk13(int hi, int lo);
        return {3'b0, hi[12:0], 3'b0, lo[12:0]};
    endfunction

    function automatic logic [31:0] ctrl_word(int s, int e);
        return {13'b0, s[2:0], 15'b0, e[0]};
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cfg();
        wr(0, pk12(pre[0], pre[1]));
        wr(1, pk12(0, pre[2]));
        wr(2, pk13(cf[0], cf[1]));
        wr(3, pk13(cf[2], cf[3]));
        wr(4, pk13(cf[4], cf[5]));
        wr(5, pk13(cf[6], cf[7]));
        wr(6, pk13(cf[8], 0));
        wr(7, pk12(post[0], post[1]));
        wr(8, pk12(0, post[2]));
        wr(9, ctrl_word(sh, en));
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // one pixel, output expected exactly three edges later
    task automatic px(logic [29:0] p, logic [29:0] exp, string tag);
        @(negedge clk); in_valid = 1'b1; pix_in = p;
        @(negedge clk); in_valid = 1'b0; pix_in = '0;
        @(negedge clk); check({tag, " R5 not early"}, {29'b0, out_valid}, 30'd0);
        @(negedge clk); check({tag, " R5 valid"}, {29'b0, out_valid}, 30'd1);
        check(tag, pix_out, exp);
    endtask

    task automatic set_709();
        pre  = '{0, 0, 0};
        cf   = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
        post = '{64, 512, 512};
        sh = 0; en = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", {29'b0, out_valid}, 30'd0);
        rst = 1'b0;
        pre = '{0, 0, 0}; cf = '{0, 0, 0, 0, 0, 0, 0, 0, 0}; post = '{0, 0, 0}; sh = 0; en = 0;
        px({10'd700, 10'd20, 10'd999}, {10'd700, 10'd20, 10'd999}, "R1 reset config passes through");

        // R7: writes without a frame pulse do nothing
        set_709();
        load_cfg();
        px({10'd1023, 10'd0, 10'd0}, {10'd1023, 10'd0, 10'd0}, "R7 no commit before frame");
        frame();

        // R9 / R8 hand values
        px(30'd0, ycc(64, 512, 512), "R9 black");
        px({10'd1023, 10'd1023, 10'd1023}, ycc(939, 512, 512), "R9 white");
        px({10'd1023, 10'd0, 10'd0}, ycc(250, 409, 960), "R8 R9 red");

        // R3 / R5: back-to-back stream against the model
        for (int k = 0; k < NSTIM + 3; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                check("R5 stream valid", {29'b0, out_valid}, 30'd1);
                check("R3 stream pixel", pix_out, model(STIM[k-3]));
            end
            if (k < NSTIM) begin in_valid = 1'b1; pix_in = STIM[k]; end
            else begin in_valid = 1'b0; pix_in = '0; end
        end
        @(negedge clk);
        check("R5 stream ends", {29'b0, out_valid}, 30'd0);

        // R2: asymmetric matrix, negative offsets, every field distinct
        pre  = '{5, -7, 3};
        cf   = '{100, -200, 300, -400, 500, -600, 700, -800, 900};
        post = '{-100, 200, 1000};
        sh = 0; en = 1;
        load_cfg(); frame();
        px({10'd800, 10'd300, 10'd50}, model({10'd800, 10'd300, 10'd50}), "R2 field layout a");
        px({10'd10, 10'd1000, 10'd600}, model({10'd10, 10'd1000, 10'd600}), "R2 field layout b");

        // R4: clip at both ends
        pre  = '{-2048, 2047, 0};
        cf   = '{1024, 0, 0, 0, 1024, 0, 0, 0, 1024};
        post = '{0, 0, 0};
        sh = 0; en = 1;
        load_cfg(); frame();
        px({10'd100, 10'd1000, 10'd600}, ycc(0, 1023, 600), "R4 clip low and high");

        // R10: extra shift
        pre = '{0, 0, 0}; sh = 1;
        load_cfg(); frame();
        px({10'd600, 10'd1023, 10'd1}, ycc(300, 511, 0), "R10 shift by one");

        // R7: write in the same cycle as the frame pulse waits a frame
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = ctrl_word(0, 1); frame_start = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
        px({10'd600, 10'd1023, 10'd1}, ycc(300, 511, 0), "R7 same-cycle write deferred");
        frame();
        px({10'd600, 10'd1023, 10'd1}, ycc(600, 1023, 1), "R7 deferred write applied");

        // R6: bypass with a real matrix loaded
        set_709(); en = 0;
        load_cfg(); frame();
        px({10'd1023, 10'd0, 10'd0}, {10'd1023, 10'd0, 10'd0}, "R6 bypass");

        // R1: reset mid-run returns to pass-through
        set_709();
        load_cfg(); frame();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 valid low after reset", {29'b0, out_valid}, 30'd0);
        px({10'd1023, 10'd0, 10'd0}, {10'd1023, 10'd0, 10'd0}, "R1 reset clears config");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule